// File: doc/BRIEF.md
# Vector Fail-First Element Sequencer

This block walks a vector operation one element at a time, from element 0 up to the vector length given at start. For each element it issues a one-cycle strobe carrying the element index. It then waits until the execution side hands back that element's status: an exception flag and a 4-bit condition value. Using that status, the block either moves on to the next element or ends the vector early. When it ends early under fail-first rules, it writes a shortened vector length back in place.

There are two termination modes. In load/store mode, a fault on element 0 is raised as an ordinary exception. A fault on any later element is absorbed instead: the vector length becomes that element's index, so only the elements before it are kept. In condition mode, which applies only when the operation writes a condition result, one selected bit of each element's condition value is tested. A set bit cancels that element and every element after it, and the vector length is cut back to the current index. The final length and the done flag stay valid until the next start.

Top module: `vff_elem_seq`

## Requirements
- R1: After reset, `done_o`, `elem_req_o` and `exc_raise_o` are low and `vl_o` is 0.
- R2: When the enable bit is clear and no exception is reported, elements 0 to VL-1 are issued in ascending order. Done then follows, with `vl_o` equal to the VL given at start.
- R3: A start with VL of 0 issues no element, and `done_o` is high on the cycle after the start cycle, with `vl_o` equal to 0.
- R4: `elem_req_o` is a one-cycle pulse. No further element is issued until the status of the current one has been accepted. The index shown with a strobe is always below the latched VL.
- R5: In load/store mode (`mode_i` = 0), an exception on element 0 pulses `exc_raise_o` in the first done cycle, ends the sequence and leaves `vl_o` equal to the start VL, whatever the enable bit.
- R6: In load/store mode with the enable bit set, an exception on element k ≥ 1 raises nothing, ends the sequence and sets `vl_o` to k.
- R7: In condition mode (`mode_i` = 1), with the enable bit and `rec_i` set, a status whose selected condition bit is 1 on element k ends the sequence with `vl_o` = k and no exception.
- R8: In condition mode with `rec_i` clear, condition values have no effect and the full VL is issued.
- R9: An exception that fail-first does not absorb (enable clear, or condition mode) pulses `exc_raise_o`, ends the sequence and keeps `vl_o` at the start VL.
- R10: In load/store mode, condition values have no effect on the sequence.
- R11: While done is high, `done_o` and `vl_o` hold until the next start. A start that arrives while elements are in flight is ignored.
- R12: The 3-bit fail-first control uses bit 2 as the enable and bits 1:0 as the index of the condition bit to test. A set condition bit at any other position does not terminate the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a vector; accepted only when idle or done |
| vl_i | input | VL_W | Vector length at start |
| mode_i | input | 1 | 0 load/store, 1 condition-driven |
| ffctl_i | input | SEL_W+1 | Fail-first control: enable in MSB, bit index below |
| rec_i | input | 1 | Operation produces a condition result |
| elem_req_o | output | 1 | One-cycle element issue strobe |
| elem_idx_o | output | VL_W | Index of the element being issued |
| st_valid_i | input | 1 | Status for the issued element is valid |
| st_exc_i | input | 1 | Element would raise an exception |
| st_cond_i | input | COND_W | Element condition value |
| exc_raise_o | output | 1 | Pulse: exception raised normally |
| vl_o | output | VL_W | Final, possibly truncated, vector length |
| done_o | output | 1 | Sequence finished; vl_o valid |

## Verification
After the start edge, the first strobe, or done for a zero length, appears in the next cycle. The status has to be presented in a cycle after the strobe cycle. Done, `exc_raise_o` and the final `vl_o` appear one cycle after the status is accepted, and the next strobe appears at that same point. The bench drives inputs and samples outputs on falling edges. It holds each status back for zero to two extra cycles, and in each of those cycles it checks that no new strobe appears. It compares the strobe count, each index, the raise pulse and the final length with values computed from the requirements.

// File: rtl/vff_pkg.sv
package vff_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_DONE  = 2'd3
   } seq_st_e;

   localparam logic MODE_LDST = 1'b0;
   localparam logic MODE_COND = 1'b1;
endpackage

// File: rtl/vff_ctl_dec.sv
module vff_ctl_dec #(
   parameter int COND_W = 4,
   localparam int SEL_W = $clog2(COND_W)
) (
   input  logic [SEL_W:0]    ctl_i,
   output logic              en_o,
   output logic [COND_W-1:0] sel_oh_o
);
   if (COND_W < 2 || (1 << SEL_W) != COND_W) begin : g_bad_cond_w
      $error("COND_W must be a power of two, at least 2");
   end

   assign en_o = ctl_i[SEL_W];

   for (genvar g = 0; g < COND_W; g++) begin : g_sel
      assign sel_oh_o[g] = (ctl_i[SEL_W-1:0] == SEL_W'(g));
   end
endmodule

// File: rtl/vff_term_eval.sv
module vff_term_eval #(
   parameter int COND_W = 4
) (
   input  logic              mode_i,
   input  logic              en_i,
   input  logic              rec_i,
   input  logic [COND_W-1:0] sel_oh_i,
   input  logic              idx_zero_i,
   input  logic              exc_i,
   input  logic [COND_W-1:0] cond_i,
   output logic              raise_o,
   output logic              trunc_o
);
   import vff_pkg::*;

   logic [COND_W-1:0] hit_vec;
   logic              cond_hit;
   logic              ldst_absorb;
   logic              cond_stop;

   for (genvar g = 0; g < COND_W; g++) begin : g_hit
      assign hit_vec[g] = cond_i[g] & sel_oh_i[g];
   end

   always_comb begin
      cond_hit    = |hit_vec;
      ldst_absorb = (mode_i == MODE_LDST) && en_i && !idx_zero_i && exc_i;
      cond_stop   = (mode_i == MODE_COND) && en_i && rec_i && cond_hit && !exc_i;
      raise_o     = exc_i && !ldst_absorb;
      trunc_o     = ldst_absorb || cond_stop;
   end

   // R9
   always_comb begin
      raise_trunc_excl_chk: assert (!(raise_o && trunc_o))
         else $error("raise and truncate at once");
   end
endmodule

// File: rtl/vff_idx_ctr.sv
module vff_idx_ctr #(
   parameter int VL_W = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_i,
   input  logic            inc_i,
   input  logic [VL_W-1:0] lim_i,
   output logic [VL_W-1:0] idx_o,
   output logic            last_o,
   output logic            zero_o
);
   logic [VL_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx_q <= '0;
      else if (clr_i) idx_q <= '0;
      else if (inc_i) idx_q <= idx_q + VL_W'(1);
   end

   assign idx_o  = idx_q;
   assign zero_o = (idx_q == '0);
   assign last_o = (idx_q == lim_i - VL_W'(1));

   // R4
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc_i |-> (idx_q != '1))
      else $error("index counter wrapped");
endmodule

// File: rtl/vff_elem_seq.sv
module vff_elem_seq #(
   parameter int VL_W   = 7,
   parameter int COND_W = 4,
   localparam int SEL_W = $clog2(COND_W),
   localparam int CTL_W = SEL_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [VL_W-1:0]   vl_i,
   input  logic              mode_i,
   input  logic [CTL_W-1:0]  ffctl_i,
   input  logic              rec_i,
   output logic              elem_req_o,
   output logic [VL_W-1:0]   elem_idx_o,
   input  logic              st_valid_i,
   input  logic              st_exc_i,
   input  logic [COND_W-1:0] st_cond_i,
   output logic              exc_raise_o,
   output logic [VL_W-1:0]   vl_o,
   output logic              done_o
);
   import vff_pkg::*;

   if (VL_W < 1) begin : g_bad_vl_w
      $error("VL_W must be at least 1");
   end

   seq_st_e           st_q;
   logic [VL_W-1:0]   vl_q;
   logic [VL_W-1:0]   vl_out_q;
   logic              mode_q;
   logic [CTL_W-1:0]  ctl_q;
   logic              rec_q;
   logic              raise_q;

   logic              accept;
   logic              take_st;
   logic              en;
   logic [COND_W-1:0] sel_oh;
   logic              raise_c;
   logic              trunc_c;
   logic              last;
   logic              idx_zero;
   logic [VL_W-1:0]   idx;
   logic              advance;

   assign accept  = start_i && ((st_q == ST_IDLE) || (st_q == ST_DONE));
   assign take_st = (st_q == ST_WAIT) && st_valid_i;
   assign advance = take_st && !raise_c && !trunc_c && !last;

   vff_ctl_dec #(.COND_W(COND_W)) u_dec (
      .ctl_i   (ctl_q),
      .en_o    (en),
      .sel_oh_o(sel_oh)
   );

   vff_term_eval #(.COND_W(COND_W)) u_eval (
      .mode_i    (mode_q),
      .en_i      (en),
      .rec_i     (rec_q),
      .sel_oh_i  (sel_oh),
      .idx_zero_i(idx_zero),
      .exc_i     (st_exc_i),
      .cond_i    (st_cond_i),
      .raise_o   (raise_c),
      .trunc_o   (trunc_c)
   );

   vff_idx_ctr #(.VL_W(VL_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (accept),
      .inc_i (advance),
      .lim_i (vl_q),
      .idx_o (idx),
      .last_o(last),
      .zero_o(idx_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         vl_q     <= '0;
         vl_out_q <= '0;
         mode_q   <= MODE_LDST;
         ctl_q    <= '0;
         rec_q    <= 1'b0;
         raise_q  <= 1'b0;
      end else begin
         raise_q <= 1'b0;
         unique case (st_q)
            ST_IDLE, ST_DONE: begin
               if (start_i) begin
                  vl_q     <= vl_i;
                  vl_out_q <= vl_i;
                  mode_q   <= mode_i;
                  ctl_q    <= ffctl_i;
                  rec_q    <= rec_i;
                  st_q     <= (vl_i == '0) ? ST_DONE : ST_ISSUE;
               end
            end
            ST_ISSUE: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (st_valid_i) begin
                  if (raise_c) begin
                     raise_q <= 1'b1;
                     st_q    <= ST_DONE;
                  end else if (trunc_c) begin
                     vl_out_q <= idx;
                     st_q     <= ST_DONE;
                  end else if (last) begin
                     st_q <= ST_DONE;
                  end else begin
                     st_q <= ST_ISSUE;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign elem_req_o  = (st_q == ST_ISSUE);
   assign elem_idx_o  = idx;
   assign done_o      = (st_q == ST_DONE);
   assign vl_o        = vl_out_q;
   assign exc_raise_o = raise_q;

   // R4
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      elem_req_o |=> !elem_req_o)
      else $error("issue strobe longer than one cycle");

   // R4
   idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      elem_req_o |-> (elem_idx_o < vl_q))
      else $error("issued index beyond VL");

   // R11
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable(vl_o)))
      else $error("done or VL changed without start");

   // R9
   raise_keeps_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_raise_o |-> (done_o && vl_o == vl_q))
      else $error("raise without done or with changed VL");

   // R5
   first_fault_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_st && mode_q == MODE_LDST && elem_idx_o == '0 && st_exc_i) |=> exc_raise_o)
      else $error("element 0 fault not raised");

   // R7
   vl_never_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (vl_o <= vl_q))
      else $error("final VL above start VL");
endmodule

// File: tb/sim_vff_elem_seq.sv
module sim_vff_elem_seq;
   localparam int VL_W   = 4;
   localparam int COND_W = 4;
   localparam int NONE   = 99;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [VL_W-1:0]  vl_i = '0;
   logic             mode_i = 1'b0;
   logic [2:0]       ffctl_i = '0;
   logic             rec_i = 1'b0;
   logic             elem_req_o;
   logic [VL_W-1:0]  elem_idx_o;
   logic             st_valid_i = 1'b0;
   logic             st_exc_i = 1'b0;
   logic [COND_W-1:0] st_cond_i = '0;
   logic             exc_raise_o;
   logic [VL_W-1:0]  vl_o;
   logic             done_o;

   int tests = 0;
   int fails = 0;
   int cyc   = 0;
   bit ended = 1'b0;

   always #5 clk = ~clk;

   vff_elem_seq #(.VL_W(VL_W), .COND_W(COND_W)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
      .mode_i(mode_i), .ffctl_i(ffctl_i), .rec_i(rec_i),
      .elem_req_o(elem_req_o), .elem_idx_o(elem_idx_o),
      .st_valid_i(st_valid_i), .st_exc_i(st_exc_i), .st_cond_i(st_cond_i),
      .exc_raise_o(exc_raise_o), .vl_o(vl_o), .done_o(done_o)
   );

   task automatic chk(bit ok, string tag, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
         end
      end
   end

   function automatic logic [3:0] cond_of(int i, int cond_at);
      if (i == cond_at) return 4'b0001 << (cond_at % 4);
      return 4'b0000;
   endfunction

   task automatic run(int vl, int md, int ctl, int rc, int exc_at, int cond_at,
                      int dly, bit poke);
      int    exp_n, exp_vl, got_n, guard, first_vl;
      bit    exp_raise, en, stopped, got_raise, hit_other;
      int    sel;
      string tag;
      en        = ctl[2];
      sel       = ctl & 3;
      exp_n     = vl;
      exp_vl    = vl;
      exp_raise = 1'b0;
      stopped   = 1'b0;
      hit_other = 1'b0;
      tag       = "R2";
      for (int i = 0; i < vl && !stopped; i++) begin
         if (i == exc_at) begin
            stopped = 1'b1;
            exp_n   = i + 1;
            if (md == 0 && en && i > 0) begin
               exp_vl = i; tag = "R6";
            end else begin
               exp_raise = 1'b1;
               tag = (md == 0 && i == 0) ? "R5" : "R9";
            end
         end else if (md == 1 && en && rc == 1 && cond_of(i, cond_at)[sel]) begin
            stopped = 1'b1;
            exp_n   = i + 1;
            exp_vl  = i;
            tag     = "R7";
         end else if (i == cond_at) begin
            hit_other = 1'b1;
         end
      end
      if (!stopped && hit_other) begin
         if (md == 0)            tag = "R10";
         else if (rc == 0)       tag = "R8";
         else if (en)            tag = "R12";
      end

      @(negedge clk);
      vl_i = VL_W'(vl); mode_i = md[0]; ffctl_i = ctl[2:0]; rec_i = rc[0];
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (vl == 0) begin
         chk(done_o == 1'b1 && elem_req_o == 1'b0, "R3", done_o, 1);
      end
      got_n = 0;
      got_raise = 1'b0;
      guard = 0;
      while (!done_o && guard < 200) begin
         if (elem_req_o) begin
            chk(int'(elem_idx_o) == got_n, "R2", elem_idx_o, got_n);
            got_n++;
            for (int d = 0; d <= dly; d++) begin
               @(negedge clk);
               chk(elem_req_o == 1'b0, "R4", elem_req_o, 0);
            end
            st_valid_i = 1'b1;
            st_exc_i   = (got_n - 1 == exc_at);
            st_cond_i  = cond_of(got_n - 1, cond_at);
            if (poke) begin
               start_i = 1'b1;
               vl_i    = '1;
            end
            @(negedge clk);
            st_valid_i = 1'b0;
            st_exc_i   = 1'b0;
            st_cond_i  = '0;
            start_i    = 1'b0;
            vl_i       = VL_W'(vl);
         end else begin
            @(negedge clk);
         end
         guard++;
      end
      got_raise = exc_raise_o;
      chk(done_o == 1'b1, tag, done_o, 1);
      chk(got_n == exp_n, tag, got_n, exp_n);
      chk(int'(vl_o) == exp_vl, tag, vl_o, exp_vl);
      chk(got_raise == exp_raise, tag, got_raise, exp_raise);
      if (poke) chk(int'(vl_o) == exp_vl, "R11", vl_o, exp_vl);
      first_vl = vl_o;
      repeat (3) @(negedge clk);
      chk(done_o == 1'b1 && int'(vl_o) == first_vl && exc_raise_o == 1'b0,
          "R11", vl_o, first_vl);
   endtask

   initial begin
      int n = 0;
      int exc_set[4]  = '{NONE, 0, 1, 3};
      int cond_set[3] = '{NONE, 0, 2};
      #1;
      chk(done_o == 1'b0 && elem_req_o == 1'b0 && exc_raise_o == 1'b0 && vl_o == '0,
          "R1", done_o, 0);
      repeat (3) @(negedge clk);
      chk(done_o == 1'b0 && elem_req_o == 1'b0 && vl_o == '0, "R1", vl_o, 0);
      rst_n = 1'b1;
      for (int vl = 0; vl <= 4; vl++)
         for (int md = 0; md < 2; md++)
            for (int ctl = 0; ctl < 8; ctl++)
               for (int rc = 0; rc < 2; rc++)
                  for (int e = 0; e < 4; e++)
                     for (int c = 0; c < 3; c++) begin
                        run(vl, md, ctl, rc, exc_set[e], cond_set[c], n % 3, (n % 7) == 3);
                        n++;
                     end
      run(15, 0, 0, 0, NONE, NONE, 0, 1'b0);
      run(15, 1, 7, 1, NONE, 14, 1, 1'b1);
      finish_run();
   end
endmodule